// File: doc/BRIEF.md
# Endurance-Limited Memory Write Guard

This block sits between the agents of a chip and a non-volatile memory whose blocks survive only a limited number of program operations. Every request carries a one-bit trust tag. The guard keeps a write counter for every physical block and compares it against a programmable maximum. A write from an untrusted agent to a block that has used up its allowance is refused and never reaches the memory. A write from the trusted agent is always passed through. The maximum sits in a control register that only the trusted agent may read or change.

The memory has eight logical blocks laid over ten physical blocks. When a granted write brings a block's count up to the maximum, the logical block is moved, on that same clock edge, to the next unused spare. The spares are physical blocks 8 and then 9, and each starts with a count of zero. Once both spares are in use, exhausted blocks stay in place and untrusted writes to them keep being refused.

Requests use a valid/ready handshake, and there is never more than one request in flight. The controller is a three-state machine:
- `GS_IDLE` accepts a request. It moves to `GS_GRANT` when the request is permitted and to `GS_DENY` when it is refused.
- `GS_GRANT` presents an OK response and returns to `GS_IDLE`.
- `GS_DENY` presents a BLOCKED response and an error pulse, then returns to `GS_IDLE`.

Top module: `nvm_wear_guard`

## Requirements
- R1: After reset the limit register holds LIMIT_RST (default 4), every block counter is zero, logical block n maps to physical block n, the sticky error bit is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: The request kind selects the operation: 0 is a memory write, 1 writes the limit register from `req_wdata`, 2 reads the limit register into `rsp_rdata`, and 3 clears the sticky error bit. A limit write or limit read from an untrusted agent (`req_trusted`=0) gets a BLOCKED response, leaves the limit unchanged, and returns `rsp_rdata`=0.
- R3: An untrusted memory write to a logical block whose physical block count is at or above the limit gets a BLOCKED response, and `mem_we` stays 0.
- R4: A trusted memory write is always granted and drives `mem_we`, whatever the block's count.
- R5: Each granted memory write adds exactly one to the counter of the physical block it targets. The counter saturates at 2^CW-1 and never wraps.
- R6: When a granted write leaves its physical block's count at or above the limit and a spare is still free, the logical block is remapped on that edge to the next spare (physical 8 first, then 9). The new block's count is zero. Later writes to that logical block go to the spare.
- R7: Once both spares are used, no further remap happens, and untrusted writes to exhausted blocks remain BLOCKED.
- R8: Every refused request raises `err_pulse` for exactly the one response cycle and sets `err_sticky`. A clear request (kind 3) from the trusted agent resets `err_sticky` and is OK. A clear from an untrusted agent is BLOCKED and leaves `err_sticky` set.
- R9: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. In the next cycle `rsp_valid` is 1 and `req_ready` is 0. `rsp_status` is 0 for OK and 1 for BLOCKED. For a granted memory write, `mem_we` and `mem_pblock` are driven in that same response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Guard can accept a request |
| req_trusted | input | 1 | 1 when the requester is the trusted agent |
| req_kind | input | 2 | Operation code (0 write, 1 limit write, 2 limit read, 3 clear) |
| req_lblock | input | $clog2(NLOG) | Logical block of a memory write |
| req_wdata | input | CW | New limit value for kind 1 |
| rsp_valid | output | 1 | Response cycle |
| rsp_status | output | 1 | 0 OK, 1 BLOCKED |
| rsp_rdata | output | CW | Limit value for a trusted kind 2, otherwise 0 |
| mem_we | output | 1 | Program command to the memory |
| mem_pblock | output | $clog2(NLOG+NSPARE) | Physical block to program |
| err_pulse | output | 1 | One-cycle refusal indicator |
| err_sticky | output | 1 | Latched refusal flag |

## Verification
The assertions assume that a requester holds `req_kind`, `req_trusted` and `req_lblock` steady in the cycle it is accepted. They also assume that `req_lblock` always names one of the eight logical blocks. The bench drives every field on the falling edge and drops `req_valid` in the response cycle, so each accepted request is seen exactly once. Logical block numbers come only from the 0 to 7 range. Limit values written in the sweep stay nonzero, so the remap assertion and the bench model start from the same premise.

// File: rtl/nvm_guard_pkg.sv
package nvm_guard_pkg;

    typedef enum logic [1:0] {
        KIND_MEM_WR   = 2'd0,
        KIND_LIM_WR   = 2'd1,
        KIND_LIM_RD   = 2'd2,
        KIND_STAT_CLR = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        GS_IDLE  = 2'd0,
        GS_GRANT = 2'd1,
        GS_DENY  = 2'd2
    } guard_state_e;

    localparam logic RSP_OK      = 1'b0;
    localparam logic RSP_BLOCKED = 1'b1;

endpackage

// File: rtl/wg_limit_reg.sv
module wg_limit_reg #(
    parameter int CW        = 8,
    parameter int LIMIT_RST = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] limit_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            limit_q <= CW'(LIMIT_RST);
        end else if (wr_en) begin
            limit_q <= wr_data;
        end
    end

endmodule

// File: rtl/wg_count_bank.sv
module wg_count_bank #(
    parameter int NPHYS = 10,
    parameter int CW    = 8,
    parameter int PW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_en,
    input  logic [PW-1:0] inc_idx,
    input  logic          clr_en,
    input  logic [PW-1:0] clr_idx,
    input  logic [PW-1:0] rd_idx,
    output logic [CW-1:0] rd_cnt
);

    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    logic [CW-1:0] cnt_arr [NPHYS];

    for (genvar g = 0; g < NPHYS; g++) begin : g_ctr
        logic [CW-1:0] c_q;
        logic          hit_inc;
        logic          hit_clr;

        assign hit_inc = inc_en && (inc_idx == PW'(g));
        assign hit_clr = clr_en && (clr_idx == PW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                c_q <= '0;
            end else if (hit_clr) begin
                c_q <= '0;
            end else if (hit_inc && (c_q != CMAX)) begin
                c_q <= c_q + 1'b1;
            end
        end

        assign cnt_arr[g] = c_q;
    end

    assign rd_cnt = cnt_arr[rd_idx];

endmodule

// File: rtl/wg_remap_table.sv
module wg_remap_table #(
    parameter int NLOG   = 8,
    parameter int NSPARE = 2,
    parameter int PW     = 4,
    parameter int LW     = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] look_lb,
    output logic [PW-1:0] look_pb,
    input  logic          remap_en,
    output logic          spare_avail,
    output logic [PW-1:0] spare_pb
);

    localparam int SPW = $clog2(NSPARE + 1);

    logic [PW-1:0]  map_q [NLOG];
    logic [SPW-1:0] next_q;

    assign spare_avail = (next_q < SPW'(NSPARE));
    assign spare_pb    = PW'(NLOG) + PW'(next_q);
    assign look_pb     = map_q[look_lb];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NLOG; i++) begin
                map_q[i] <= PW'(i);
            end
            next_q <= '0;
        end else if (remap_en && spare_avail) begin
            map_q[look_lb] <= spare_pb;
            next_q         <= next_q + 1'b1;
        end
    end

endmodule

// File: rtl/nvm_wear_guard.sv
module nvm_wear_guard
    import nvm_guard_pkg::*;
#(
    parameter int NLOG      = 8,
    parameter int NSPARE    = 2,
    parameter int CW        = 8,
    parameter int LIMIT_RST = 4,
    localparam int NPHYS    = NLOG + NSPARE,
    localparam int PW       = $clog2(NPHYS),
    localparam int LW       = $clog2(NLOG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_trusted,
    input  logic [1:0]    req_kind,
    input  logic [LW-1:0] req_lblock,
    input  logic [CW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic          rsp_status,
    output logic [CW-1:0] rsp_rdata,
    output logic          mem_we,
    output logic [PW-1:0] mem_pblock,
    output logic          err_pulse,
    output logic          err_sticky
);

    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    guard_state_e  state_q, state_d;
    req_kind_e     kind;
    logic          accept;
    logic          permit;
    logic [PW-1:0] cur_pb;
    logic [CW-1:0] cur_cnt;
    logic [CW-1:0] cnt_next;
    logic          cur_at_limit;
    logic          grant_mem;
    logic          do_remap;
    logic          spare_avail;
    logic [PW-1:0] spare_pb;
    logic [CW-1:0] limit_q;
    logic          lim_wr_en;
    logic          wr_q;
    logic [PW-1:0] pb_q;
    logic [CW-1:0] rdata_q;
    logic          sticky_q;

    assign kind   = req_kind_e'(req_kind);
    assign accept = req_valid && req_ready;

    wg_limit_reg #(
        .CW       (CW),
        .LIMIT_RST(LIMIT_RST)
    ) u_limit (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (lim_wr_en),
        .wr_data(req_wdata),
        .limit_q(limit_q)
    );

    wg_remap_table #(
        .NLOG  (NLOG),
        .NSPARE(NSPARE),
        .PW    (PW),
        .LW    (LW)
    ) u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_lb    (req_lblock),
        .look_pb    (cur_pb),
        .remap_en   (do_remap),
        .spare_avail(spare_avail),
        .spare_pb   (spare_pb)
    );

    wg_count_bank #(
        .NPHYS(NPHYS),
        .CW   (CW),
        .PW   (PW)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_en (grant_mem),
        .inc_idx(cur_pb),
        .clr_en (do_remap),
        .clr_idx(spare_pb),
        .rd_idx (cur_pb),
        .rd_cnt (cur_cnt)
    );

    // Access decision for the request presented in GS_IDLE
    assign cur_at_limit = (cur_cnt >= limit_q);
    assign cnt_next     = (cur_cnt == CMAX) ? CMAX : (cur_cnt + 1'b1);

    always_comb begin
        unique case (kind)
            KIND_MEM_WR:   permit = req_trusted || !cur_at_limit;
            KIND_LIM_WR,
            KIND_LIM_RD,
            KIND_STAT_CLR: permit = req_trusted;
            default:       permit = 1'b0;
        endcase
    end

    assign grant_mem = accept && (kind == KIND_MEM_WR) && permit;
    assign do_remap  = grant_mem && (cnt_next >= limit_q) && spare_avail;
    assign lim_wr_en = accept && (kind == KIND_LIM_WR) && req_trusted;

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_IDLE: begin
                if (accept) begin
                    state_d = permit ? GS_GRANT : GS_DENY;
                end
            end
            GS_GRANT: state_d = GS_IDLE;
            GS_DENY:  state_d = GS_IDLE;
            default:  state_d = GS_IDLE;
        endcase
    end

    // State register and response payload
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= GS_IDLE;
            wr_q     <= 1'b0;
            pb_q     <= '0;
            rdata_q  <= '0;
            sticky_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                wr_q    <= grant_mem;
                pb_q    <= cur_pb;
                rdata_q <= ((kind == KIND_LIM_RD) && req_trusted) ? limit_q : '0;
                if (!permit) begin
                    sticky_q <= 1'b1;
                end else if (kind == KIND_STAT_CLR) begin
                    sticky_q <= 1'b0;
                end
            end
        end
    end

    // Output process
    always_comb begin
        req_ready  = 1'b0;
        rsp_valid  = 1'b0;
        rsp_status = RSP_OK;
        rsp_rdata  = '0;
        mem_we     = 1'b0;
        mem_pblock = '0;
        err_pulse  = 1'b0;
        unique case (state_q)
            GS_IDLE: begin
                req_ready = 1'b1;
            end
            GS_GRANT: begin
                rsp_valid  = 1'b1;
                rsp_rdata  = rdata_q;
                mem_we     = wr_q;
                mem_pblock = wr_q ? pb_q : '0;
            end
            GS_DENY: begin
                rsp_valid  = 1'b1;
                rsp_status = RSP_BLOCKED;
                err_pulse  = 1'b1;
            end
            default: begin
                req_ready = 1'b0;
            end
        endcase
    end

    assign err_sticky = sticky_q;

endmodule

// File: rtl/nvm_wear_guard_chk.sv
module nvm_wear_guard_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          req_trusted,
    input logic [1:0]    req_kind,
    input logic          rsp_valid,
    input logic          rsp_status,
    input logic          mem_we,
    input logic          err_pulse,
    input logic          err_sticky,
    input logic          cur_at_limit,
    input logic [CW-1:0] limit_q
);

    logic acc;
    assign acc = req_valid && req_ready;

    a_r2_limit_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_trusted && (req_kind == 2'd1)) |=> $stable(limit_q));

    a_r3_untrusted_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_trusted && (req_kind == 2'd0) && cur_at_limit)
            |=> (rsp_status && !mem_we));

    a_r4_trusted_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_trusted && (req_kind == 2'd0))
            |=> (rsp_valid && !rsp_status && mem_we));

    a_r8_pulse_with_block: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (rsp_valid && rsp_status && err_sticky));

    a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !err_pulse);

    a_r9_response_next: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (rsp_valid && !req_ready));

    a_r9_write_only_ok: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (rsp_valid && !rsp_status));

endmodule

bind nvm_wear_guard nvm_wear_guard_chk #(.CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_trusted (req_trusted),
    .req_kind    (req_kind),
    .rsp_valid   (rsp_valid),
    .rsp_status  (rsp_status),
    .mem_we      (mem_we),
    .err_pulse   (err_pulse),
    .err_sticky  (err_sticky),
    .cur_at_limit(cur_at_limit),
    .limit_q     (limit_q)
);

// File: tb/nvm_wear_guard_test.sv
`timescale 1ns/1ps
module nvm_wear_guard_test;

    localparam int NLOG   = 8;
    localparam int NSPARE = 2;
    localparam int CW     = 4;
    localparam int LRST   = 4;
    localparam int NPHYS  = NLOG + NSPARE;
    localparam int CMAX   = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic          req_ready;
    logic          req_trusted;
    logic [1:0]    req_kind;
    logic [2:0]    req_lblock;
    logic [CW-1:0] req_wdata;
    logic          rsp_valid;
    logic          rsp_status;
    logic [CW-1:0] rsp_rdata;
    logic          mem_we;
    logic [3:0]    mem_pblock;
    logic          err_pulse;
    logic          err_sticky;

    always #2 clk = ~clk;

    nvm_wear_guard #(
        .NLOG(NLOG), .NSPARE(NSPARE), .CW(CW), .LIMIT_RST(LRST)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_trusted(req_trusted), .req_kind(req_kind), .req_lblock(req_lblock),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
        .rsp_rdata(rsp_rdata), .mem_we(mem_we), .mem_pblock(mem_pblock),
        .err_pulse(err_pulse), .err_sticky(err_sticky)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int m_map [NLOG];
    int m_cnt [NPHYS];
    int m_next;
    int m_limit;
    int m_sticky;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_req(int t, int kind, int lb, int wd, string req);
        int e_ok = 1;
        int e_we = 0;
        int e_pb = 0;
        int e_rd = 0;
        if (kind == 0) begin
            int pb = m_map[lb];
            int c  = m_cnt[pb];
            if (t == 0 && c >= m_limit) begin
                e_ok = 0;
            end else begin
                int cn = (c == CMAX) ? CMAX : c + 1;
                e_we = 1;
                e_pb = pb;
                m_cnt[pb] = cn;
                if (cn >= m_limit && m_next < NSPARE) begin
                    m_map[lb] = NLOG + m_next;
                    m_cnt[NLOG + m_next] = 0;
                    m_next++;
                end
            end
        end else begin
            e_ok = t;
            if (t == 1 && kind == 1) m_limit = wd;
            if (t == 1 && kind == 2) e_rd = m_limit;
            if (t == 1 && kind == 3) m_sticky = 0;
        end
        if (e_ok == 0) m_sticky = 1;

        @(negedge clk);
        chk(req, "ready before request", int'(req_ready), 1);
        chk("R8", "pulse idle", int'(err_pulse), 0);
        req_valid   = 1'b1;
        req_trusted = t[0];
        req_kind    = kind[1:0];
        req_lblock  = lb[2:0];
        req_wdata   = wd[CW-1:0];
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9", "rsp_valid", int'(rsp_valid), 1);
        chk("R9", "ready in response", int'(req_ready), 0);
        chk(req, "status", int'(rsp_status), e_ok ? 0 : 1);
        chk(req, "mem_we", int'(mem_we), e_we);
        if (e_we == 1) chk(req, "mem_pblock", int'(mem_pblock), e_pb);
        chk(req, "rdata", int'(rsp_rdata), e_rd);
        chk("R8", "err_pulse", int'(err_pulse), e_ok ? 0 : 1);
        chk("R8", "err_sticky", int'(err_sticky), m_sticky);
    endtask

    function automatic string tag_of(int kind);
        case (kind)
            0:       return "R5";
            1, 2:    return "R2";
            default: return "R8";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_trusted = 1'b0;
        req_kind = 2'd0; req_lblock = 3'd0; req_wdata = '0;
        for (int i = 0; i < NLOG; i++) m_map[i] = i;
        for (int i = 0; i < NPHYS; i++) m_cnt[i] = 0;
        m_next = 0; m_limit = LRST; m_sticky = 0;
        repeat (3) @(negedge clk);
        chk("R1", "ready in reset", int'(req_ready), 1);
        chk("R1", "rsp_valid in reset", int'(rsp_valid), 0);
        chk("R1", "sticky in reset", int'(err_sticky), 0);
        chk("R1", "mem_we in reset", int'(mem_we), 0);
        rst_n = 1'b1;

        // R1: default limit readable, identity mapping on first writes
        do_req(1, 2, 0, 0, "R1");
        for (int lb = 0; lb < NLOG; lb++) do_req(0, 0, lb, 0, "R1");

        // R2 and R8: refused register accesses
        do_req(0, 1, 0, 9, "R2");
        do_req(1, 2, 0, 0, "R2");
        do_req(0, 2, 0, 0, "R2");
        do_req(0, 3, 0, 0, "R8");
        do_req(1, 3, 0, 0, "R8");

        // R5, R6, R7, R3: wear logical block 0 through both spares
        for (int n = 0; n < 12; n++) do_req(0, 0, 0, 0, (n < 11) ? "R6" : "R7");
        do_req(0, 0, 0, 0, "R3");
        do_req(1, 0, 0, 0, "R4");
        for (int n = 0; n < 5; n++) do_req(0, 0, 1, 0, "R7");
        do_req(1, 0, 1, 0, "R4");
        do_req(1, 3, 0, 0, "R8");

        // R5: saturation with a raised limit
        do_req(1, 1, 0, CMAX, "R2");
        for (int n = 0; n < CMAX + 5; n++) do_req(1, 0, 2, 0, "R5");
        do_req(0, 0, 2, 0, "R5");
        do_req(0, 0, 0, 0, "R3");

        // Sweep over kind, trust and block
        for (int k = 0; k < 4; k++)
            for (int t = 0; t < 2; t++)
                for (int lb = 0; lb < NLOG; lb++)
                    do_req(t, k, lb, lb + 2, tag_of(k));
        for (int r = 0; r < 3; r++)
            for (int lb = 0; lb < NLOG; lb++)
                do_req(lb % 2, 0, lb, 0, "R3");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule